// File: doc/BRIEF.md
# Strap-Addressed SMBus Register Slave

This block is a two-wire serial slave that holds a small byte-wide register file. It oversamples SCL and SDA with the system clock and recognises start and stop conditions. It takes in bytes MSB first. It answers a single 7-bit device address, which comes from two strap inputs. It drives SDA open-drain through one output-enable: high means the pad pulls the line low. A host inside the chip reads and writes the same register file through a parallel port.

A bus write carries at most two bytes. The first byte sets an internal register pointer. The optional second byte is stored at the register that pointer selects. A bus read returns one byte from the register the pointer currently selects. The pointer keeps its value between transactions, so reading the same register again needs no new pointer write.

The strap-derived address follows the strap pins until the first address byte that matches it. It is frozen on the SCL rising edge that samples the eighth bit of that byte. From then until reset, the strap pins are ignored.

The host write port uses a valid/ready handshake. A write is taken on a clock edge where `host_wr_valid` and `host_wr_ready` are both high. The host must hold the address and data steady while valid is high and ready is low. Ready drops for exactly the one cycle in which a bus write reaches the register file, because the bus takes priority. Host reads are combinational and have no handshake.

Top module: `smb_strap_slave`

## Requirements
- R1: With `strap_aen` high, the slave answers address 0x2E whatever the level of `strap_asel`.
- R2: With `strap_aen` low, `strap_asel` low selects address 0x2C and `strap_asel` high selects 0x2D.
- R3: Until it is frozen, the answered address follows the straps. A strap change made before the eighth SCL rise of an address byte takes effect for that byte. The address is frozen by the first address byte whose upper seven bits match the strap address at that rise.
- R4: Once the address is frozen, strap changes have no effect on which address is acknowledged. Only reset unfreezes it.
- R5: Every byte takes nine SCL clocks: eight data bits, MSB first, then an acknowledge slot. The slave changes its SDA drive only while SCL is low. The one exception is a start or stop condition, which releases SDA.
- R6: The slave acknowledges a matching address by holding SDA low through the ninth clock. For a non-matching address it leaves SDA released, ignores every later byte, and alters no register or pointer until the next start.
- R7: In a write (R/W bit = 0), the first byte after the address loads the pointer and is acknowledged. The second byte is written to the register selected by the pointer's low log2(REG_DEPTH) bits and is acknowledged; higher pointer bits are ignored.
- R8: A write that ends after the pointer byte changes the pointer but no register.
- R9: A read (R/W bit = 1) shifts out, MSB first, the register the current pointer selects. No pointer write is needed beforehand. The pointer persists across transactions and resets to 0.
- R10: After the ninth clock of the read byte, the slave releases SDA whether the master acknowledged or not, so further read clocks return 0xFF. A third byte in a write is neither acknowledged nor stored.
- R11: A repeated start in the middle of a transaction begins a new address phase. A pointer set before the repeated start selects the register for a read that follows it.
- R12: After reset, every register reads 0, `sda_oe` is low and `host_wr_ready` is high. `host_rd_data` shows the register at `host_rd_addr` combinationally. A host write is taken when valid and ready are both high. `host_wr_ready` is low only during the single cycle in which a bus write lands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | High pulls SDA low (open-drain enable) |
| strap_aen | input | 1 | Address strap: high selects the fixed address 0x2E |
| strap_asel | input | 1 | Address strap: picks 0x2C or 0x2D when `strap_aen` is low |
| host_wr_valid | input | 1 | Host write request |
| host_wr_ready | output | 1 | Host write accepted on this edge if valid |
| host_wr_addr | input | log2(REG_DEPTH) | Host write register index |
| host_wr_data | input | 8 | Host write data |
| host_rd_addr | input | log2(REG_DEPTH) | Host read register index |
| host_rd_data | output | 8 | Register contents at `host_rd_addr` |

## Verification
The bench changes the straps between the seventh and eighth SCL rise of an address byte. A design that froze the address too early, or decided the match only at the acknowledge slot, would refuse that byte, or would follow a later strap change. It sends a pointer-only write, a three-byte write and a write to a foreign address, then inspects the register file through the host port. A design that stored a byte without a full pointer phase, or kept listening after a mismatch, would show the corrupted register there. It also reads with a master acknowledge and issues a repeated start after a pointer write. A slave that went on driving SDA would return a value other than 0xFF, and one that lost the pointer across the restart would return the wrong register. It uses a pointer byte with bits above the index width. A monitor counts SDA drive changes made while SCL is high and counts cycles with ready low.

// File: rtl/smb_pkg.sv
package smb_pkg;

  // Transaction phase of the serial slave
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,   // waiting for a start condition
    ST_ADDR = 3'd1,   // shifting in the device address byte
    ST_PTR  = 3'd2,   // shifting in the pointer byte
    ST_DATA = 3'd3,   // shifting in the single data byte
    ST_RD   = 3'd4    // shifting out one register byte
  } smb_state_t;

  // Strap-selected device addresses
  localparam logic [6:0] DEV_ADDR_FIXED = 7'h2E;
  localparam logic [6:0] DEV_ADDR_SEL0  = 7'h2C;
  localparam logic [6:0] DEV_ADDR_SEL1  = 7'h2D;

  // Bit counter positions within a nine-clock byte
  localparam logic [3:0] BIT_LAST_ADDR = 4'd7;  // rises so far before the R/W rise
  localparam logic [3:0] BIT_ACK_SLOT  = 4'd8;  // eight bits shifted, ack slot next
  localparam logic [3:0] BIT_ACK_DONE  = 4'd9;  // ninth rise seen

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_prev;
  logic              sda_prev;
  logic              scl_q;
  logic              sda_q;

  // Synchronizer chain; idle bus level is high
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe[g] <= 1'b1;
          sda_pipe[g] <= 1'b1;
        end else begin
          scl_pipe[g] <= scl_i;
          sda_pipe[g] <= sda_i;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe[g] <= 1'b1;
          sda_pipe[g] <= 1'b1;
        end else begin
          scl_pipe[g] <= scl_pipe[g-1];
          sda_pipe[g] <= sda_pipe[g-1];
        end
      end
    end
  end

  assign scl_q = scl_pipe[STAGES-1];
  assign sda_q = sda_pipe[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_prev <= scl_q;
      sda_prev <= sda_q;
    end
  end

  assign sda_s     = sda_q;
  assign scl_rise  = scl_q & ~scl_prev;
  assign scl_fall  = ~scl_q & scl_prev;
  // SDA edges while SCL stays high mark bus conditions
  assign start_det = scl_q & scl_prev & sda_prev & ~sda_q;
  assign stop_det  = scl_q & scl_prev & ~sda_prev & sda_q;

endmodule

// File: rtl/smb_addr_select.sv
module smb_addr_select
  import smb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strap_aen,
  input  logic       strap_asel,
  input  logic       try_i,     // eighth SCL rise of an address byte
  input  logic [6:0] cand_i,    // seven address bits received
  output logic       match_o
);

  logic [6:0] strap_addr;
  logic [6:0] held_addr;
  logic [6:0] active_addr;
  logic       frozen;

  always_comb begin
    if (strap_aen)       strap_addr = DEV_ADDR_FIXED;
    else if (strap_asel) strap_addr = DEV_ADDR_SEL1;
    else                 strap_addr = DEV_ADDR_SEL0;
  end

  assign active_addr = frozen ? held_addr : strap_addr;
  assign match_o     = (cand_i == active_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frozen    <= 1'b0;
      held_addr <= 7'h00;
    end else if (try_i && match_o && !frozen) begin
      frozen    <= 1'b1;
      held_addr <= strap_addr;
    end
  end

  AST_FREEZE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |=> frozen);  // R4
  AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |=> $stable(active_addr));  // R4
  AST_FREEZE_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frozen) |-> $past(try_i && match_o));  // R3

endmodule

// File: rtl/smb_regfile.sv
module smb_regfile #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  input  logic          host_wr_valid,
  output logic          host_wr_ready,
  input  logic [AW-1:0] host_wr_addr,
  input  logic [7:0]    host_wr_data,
  input  logic [AW-1:0] host_rd_addr,
  output logic [7:0]    host_rd_data
);

  logic [7:0] mem_q [DEPTH];
  logic       host_take;

  // Bus write has priority; host is held off for that cycle
  assign host_wr_ready = ~bus_we;
  assign host_take     = host_wr_valid & host_wr_ready;

  for (genvar g = 0; g < DEPTH; g++) begin : g_reg
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= 8'h00;
      end else if (bus_we && (bus_addr == AW'(g))) begin
        q <= bus_wdata;
      end else if (host_take && (host_wr_addr == AW'(g))) begin
        q <= host_wr_data;
      end
    end
    assign mem_q[g] = q;
  end

  assign bus_rdata    = mem_q[bus_addr];
  assign host_rd_data = mem_q[host_rd_addr];

  AST_BUS_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |=> (mem_q[$past(bus_addr)] == $past(bus_wdata)));  // R7
  AST_HOST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    host_take |=> (mem_q[$past(host_wr_addr)] == $past(host_wr_data)));  // R12

endmodule

// File: rtl/smb_strap_slave.sv
module smb_strap_slave
  import smb_pkg::*;
#(
  parameter int REG_DEPTH   = 16,
  parameter int SYNC_STAGES = 2,
  localparam int RAW = $clog2(REG_DEPTH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           scl_i,
  input  logic           sda_i,
  output logic           sda_oe,
  input  logic           strap_aen,
  input  logic           strap_asel,
  input  logic           host_wr_valid,
  output logic           host_wr_ready,
  input  logic [RAW-1:0] host_wr_addr,
  input  logic [7:0]     host_wr_data,
  input  logic [RAW-1:0] host_rd_addr,
  output logic [7:0]     host_rd_data
);

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  smb_state_t     state;
  logic [3:0]     cnt;
  logic [7:0]     shreg;
  logic [7:0]     tx;
  logic [RAW-1:0] ptr;
  logic           addr_hit;
  logic           sda_oe_q;
  logic           match_try;
  logic           addr_match;
  logic           byte_end;
  logic           ack_end;
  logic           bus_we;
  logic [7:0]     rd_byte;

  assign match_try = (state == ST_ADDR) && scl_rise && (cnt == BIT_LAST_ADDR);
  assign byte_end  = scl_fall && (cnt == BIT_ACK_SLOT);
  assign ack_end   = scl_fall && (cnt == BIT_ACK_DONE);
  assign bus_we    = (state == ST_DATA) && byte_end;

  smb_addr_select u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .strap_aen  (strap_aen),
    .strap_asel (strap_asel),
    .try_i      (match_try),
    .cand_i     (shreg[6:0]),
    .match_o    (addr_match)
  );

  smb_regfile #(.DEPTH(REG_DEPTH)) u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_we        (bus_we),
    .bus_addr      (ptr),
    .bus_wdata     (shreg),
    .bus_rdata     (rd_byte),
    .host_wr_valid (host_wr_valid),
    .host_wr_ready (host_wr_ready),
    .host_wr_addr  (host_wr_addr),
    .host_wr_data  (host_wr_data),
    .host_rd_addr  (host_rd_addr),
    .host_rd_data  (host_rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= 4'd0;
      shreg    <= 8'h00;
      tx       <= 8'h00;
      ptr      <= '0;
      addr_hit <= 1'b0;
      sda_oe_q <= 1'b0;
    end else if (start_det) begin
      state    <= ST_ADDR;
      cnt      <= 4'd0;
      sda_oe_q <= 1'b0;
    end else if (stop_det) begin
      state    <= ST_IDLE;
      cnt      <= 4'd0;
      sda_oe_q <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR, ST_PTR, ST_DATA: begin
          if (scl_rise) begin
            if (cnt < BIT_ACK_SLOT) shreg <= {shreg[6:0], sda_s};
            if (match_try) addr_hit <= addr_match;
            cnt <= cnt + 4'd1;
          end else if (byte_end) begin
            if (state == ST_ADDR && !addr_hit) begin
              state <= ST_IDLE;   // not ours: stay silent
              cnt   <= 4'd0;
            end else begin
              sda_oe_q <= 1'b1;   // acknowledge
              if (state == ST_PTR) ptr <= shreg[RAW-1:0];
            end
          end else if (ack_end) begin
            sda_oe_q <= 1'b0;
            cnt      <= 4'd0;
            if (state == ST_ADDR) begin
              if (shreg[0]) begin
                state    <= ST_RD;
                tx       <= {rd_byte[6:0], 1'b0};
                sda_oe_q <= ~rd_byte[7];
              end else begin
                state <= ST_PTR;
              end
            end else if (state == ST_PTR) begin
              state <= ST_DATA;
            end else begin
              state <= ST_IDLE;   // at most one data byte
            end
          end
        end
        ST_RD: begin
          if (scl_rise) begin
            cnt <= cnt + 4'd1;
          end else if (scl_fall) begin
            if (cnt < BIT_ACK_SLOT) begin
              sda_oe_q <= ~tx[7];
              tx       <= {tx[6:0], 1'b0};
            end else if (cnt == BIT_ACK_SLOT) begin
              sda_oe_q <= 1'b0;   // master owns the ack slot
            end else begin
              sda_oe_q <= 1'b0;
              state    <= ST_IDLE;
              cnt      <= 4'd0;
            end
          end
        end
        default: begin
          cnt <= 4'd0;
        end
      endcase
    end
  end

  assign sda_oe = sda_oe_q;

  AST_SDA_MOVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe_q != $past(sda_oe_q)) |-> $past(scl_fall || start_det || stop_det));  // R5
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= BIT_ACK_DONE);  // R5
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe_q);  // R6
  AST_WRITE_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |=> sda_oe_q);  // R7
  AST_PTR_HELD_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RD) |=> $stable(ptr));  // R9

endmodule

// File: tb/smb_strap_slave_bench.sv
module smb_strap_slave_bench;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 10;      // clocks per SCL half period
  localparam int DEPTH      = 16;
  localparam int AW         = 4;
  localparam int WDOG       = 150000;

  // {pointer byte, data byte}; 0x13 lands in register 3
  localparam logic [15:0] VEC [6] = '{
    16'h00A5, 16'h0F3C, 16'h0781, 16'h135A, 16'h0AFF, 16'h0100
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          m_scl = 1'b1;
  logic          m_sda = 1'b1;
  logic          sda_oe;
  logic          strap_aen = 1'b1;
  logic          strap_asel = 1'b0;
  logic          host_wr_valid = 1'b0;
  logic          host_wr_ready;
  logic [AW-1:0] host_wr_addr = '0;
  logic [7:0]    host_wr_data = 8'h00;
  logic [AW-1:0] host_rd_addr = '0;
  logic [7:0]    host_rd_data;
  wire           sda_line = m_sda & ~sda_oe;

  int  checks = 0;
  int  fails = 0;
  int  viol = 0;
  int  lowcnt = 0;
  bit  done = 1'b0;
  int  chg_bit = -1;
  logic chg_aen = 1'b0;
  logic chg_asel = 1'b0;
  logic prev_oe = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  smb_strap_slave u_smb_strap_slave (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_i         (m_scl),
    .sda_i         (sda_line),
    .sda_oe        (sda_oe),
    .strap_aen     (strap_aen),
    .strap_asel    (strap_asel),
    .host_wr_valid (host_wr_valid),
    .host_wr_ready (host_wr_ready),
    .host_wr_addr  (host_wr_addr),
    .host_wr_data  (host_wr_data),
    .host_rd_addr  (host_rd_addr),
    .host_rd_data  (host_rd_data)
  );

  // R5 monitor: drive changes while SCL high; R12 monitor: ready low cycles
  always @(negedge clk) begin
    if (rst_n) begin
      if (sda_oe !== prev_oe && m_scl) viol++;
      if (!host_wr_ready) lowcnt++;
    end
    prev_oe = sda_oe;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic aen, input logic asel);
    strap_aen = aen; strap_asel = asel;
    rst_n = 1'b0; m_scl = 1'b1; m_sda = 1'b1;
    waitc(4);
    rst_n = 1'b1;
    waitc(4);
  endtask

  task automatic bus_start;
    m_sda = 1'b1; waitc(HALF);
    m_scl = 1'b1; waitc(HALF);
    m_sda = 1'b0; waitc(HALF);
    m_scl = 1'b0;
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; waitc(HALF);
    m_scl = 1'b1; waitc(HALF);
    m_sda = 1'b1; waitc(HALF);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i];
      if (i == chg_bit) begin strap_aen = chg_aen; strap_asel = chg_asel; end
      waitc(HALF); m_scl = 1'b1; waitc(HALF); m_scl = 1'b0;
    end
    m_sda = 1'b1;
    waitc(HALF); m_scl = 1'b1; waitc(HALF/2);
    ack = ~sda_line;
    waitc(HALF/2); m_scl = 1'b0;
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitc(HALF); m_scl = 1'b1; waitc(HALF/2);
      b[i] = sda_line;
      waitc(HALF/2); m_scl = 1'b0;
    end
    m_sda = nack;
    waitc(HALF); m_scl = 1'b1; waitc(HALF); m_scl = 1'b0;
  endtask

  task automatic addr_probe(input logic [6:0] a, output logic ack);
    bus_start; send_byte({a, 1'b0}, ack); bus_stop;
  endtask

  task automatic wr_reg(input logic [6:0] a, input logic [7:0] p, input logic [7:0] d,
                        output logic [2:0] acks);
    bus_start;
    send_byte({a, 1'b0}, acks[2]);
    send_byte(p, acks[1]);
    send_byte(d, acks[0]);
    bus_stop;
  endtask

  task automatic set_ptr(input logic [6:0] a, input logic [7:0] p, output logic [1:0] acks);
    bus_start;
    send_byte({a, 1'b0}, acks[1]);
    send_byte(p, acks[0]);
    bus_stop;
  endtask

  task automatic rd_cur(input logic [6:0] a, output logic [7:0] d, output logic ack);
    bus_start;
    send_byte({a, 1'b1}, ack);
    recv_byte(1'b1, d);
    bus_stop;
  endtask

  task automatic hread(input int idx, output logic [7:0] d);
    host_rd_addr = AW'(idx);
    #1 d = host_rd_data;
  endtask

  task automatic hwrite(input int idx, input logic [7:0] d);
    host_wr_valid = 1'b1; host_wr_addr = AW'(idx); host_wr_data = d;
    @(posedge clk);
    while (!host_wr_ready) @(posedge clk);
    @(negedge clk);
    host_wr_valid = 1'b0;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary;
      $finish;
    end
  end

  localparam logic [6:0] A2E = 7'h2E;
  localparam logic [6:0] A2C = 7'h2C;
  localparam logic [6:0] A2D = 7'h2D;

  initial begin
    logic [7:0] d;
    logic       ack;
    logic [2:0] a3;
    logic [1:0] a2;

    do_reset(1'b1, 1'b0);

    // R12 reset state
    chk("R12", "sda_oe after reset", int'(sda_oe), 0);
    chk("R12", "ready after reset", int'(host_wr_ready), 1);
    for (int i = 0; i < DEPTH; i++) begin
      hread(i, d);
      chk("R12", "register after reset", int'(d), 0);
    end

    // R9: read with no pointer write uses pointer 0; R12 host write
    hwrite(0, 8'h96);
    rd_cur(A2E, d, ack);
    chk("R9", "read ack at reset pointer", int'(ack), 1);
    chk("R9", "read reg0 at reset pointer", int'(d), 8'h96);

    // R7 table: write, host readback, pointer write + bus readback
    for (int v = 0; v < 6; v++) begin
      logic [7:0] p, dv;
      p = VEC[v][15:8]; dv = VEC[v][7:0];
      wr_reg(A2E, p, dv, a3);
      chk("R7", "write acks", int'(a3), 3'b111);
      hread(int'(p[AW-1:0]), d);
      chk("R7", "host view of bus write", int'(d), int'(dv));
      set_ptr(A2E, p, a2);
      rd_cur(A2E, d, ack);
      chk("R9", "bus readback", int'(d), int'(dv));
    end

    // R8: pointer-only write leaves register, pointer persists (R9)
    hwrite(5, 8'h44);
    set_ptr(A2E, 8'h05, a2);
    chk("R8", "pointer-only acks", int'(a2), 2'b11);
    hread(5, d);
    chk("R8", "reg5 untouched", int'(d), 8'h44);
    rd_cur(A2E, d, ack);
    chk("R9", "pointer persists", int'(d), 8'h44);

    // R10: third write byte ignored
    wr_reg(A2E, 8'h08, 8'h11, a3);
    bus_start; send_byte({A2E, 1'b0}, ack); send_byte(8'h08, ack); send_byte(8'h11, ack);
    send_byte(8'h22, ack); bus_stop;
    chk("R10", "third byte not acked", int'(ack), 0);
    hread(8, d);
    chk("R10", "reg8 holds data byte", int'(d), 8'h11);
    hread(9, d);
    chk("R10", "reg9 not written", int'(d), 0);

    // R10: master acks the read byte; slave still releases
    bus_start; send_byte({A2E, 1'b1}, ack);
    recv_byte(1'b0, d);
    chk("R10", "read byte with master ack", int'(d), 8'h11);
    recv_byte(1'b1, d);
    chk("R10", "released after one byte", int'(d), 8'hFF);
    bus_stop;
    chk("R10", "sda_oe idle after read", int'(sda_oe), 0);

    // R11: pointer write, repeated start, read
    bus_start; send_byte({A2E, 1'b0}, ack); send_byte(8'h0F, ack);
    bus_start; send_byte({A2E, 1'b1}, ack);
    chk("R11", "addr ack after repeated start", int'(ack), 1);
    recv_byte(1'b1, d); bus_stop;
    chk("R11", "read after repeated start", int'(d), 8'h3C);

    // R6: foreign address, then bytes
    bus_start; send_byte({A2D, 1'b0}, ack);
    chk("R6", "foreign address not acked", int'(ack), 0);
    send_byte(8'h02, ack);
    chk("R6", "byte after foreign address", int'(ack), 0);
    send_byte(8'h77, ack); bus_stop;
    hread(2, d);
    chk("R6", "reg2 untouched", int'(d), 0);
    rd_cur(A2E, d, ack);
    chk("R6", "pointer untouched", int'(d), 8'h3C);

    // R12: ready low exactly one cycle per bus write
    lowcnt = 0;
    wr_reg(A2E, 8'h0C, 8'h5E, a3);
    chk("R12", "ready low cycles per bus write", lowcnt, 1);

    // R1: fixed address, select ignored
    do_reset(1'b1, 1'b1);
    addr_probe(A2C, ack); chk("R1", "0x2C refused with aen high", int'(ack), 0);
    addr_probe(A2D, ack); chk("R1", "0x2D refused with aen high", int'(ack), 0);
    addr_probe(A2E, ack); chk("R1", "0x2E acked, asel high", int'(ack), 1);

    // R2: select strap
    do_reset(1'b0, 1'b0);
    addr_probe(A2D, ack); chk("R2", "0x2D refused, asel low", int'(ack), 0);
    addr_probe(A2C, ack); chk("R2", "0x2C acked, asel low", int'(ack), 1);
    do_reset(1'b0, 1'b1);
    addr_probe(A2E, ack); chk("R2", "0x2E refused, asel high", int'(ack), 0);
    addr_probe(A2D, ack); chk("R2", "0x2D acked, asel high", int'(ack), 1);

    // R3: straps tracked until first match, change before 8th rise counts
    do_reset(1'b1, 1'b0);
    addr_probe(A2C, ack); chk("R3", "0x2C refused before change", int'(ack), 0);
    chg_bit = 0; chg_aen = 1'b0; chg_asel = 1'b0;
    bus_start; send_byte({A2C, 1'b0}, ack); bus_stop;
    chg_bit = -1;
    chk("R3", "strap change before 8th rise", int'(ack), 1);

    // R4: frozen address survives strap changes
    strap_aen = 1'b1; strap_asel = 1'b1;
    waitc(4);
    addr_probe(A2E, ack); chk("R4", "new strap address refused", int'(ack), 0);
    addr_probe(A2C, ack); chk("R4", "frozen address still acked", int'(ack), 1);
    strap_aen = 1'b0;
    waitc(4);
    addr_probe(A2D, ack); chk("R4", "0x2D refused after freeze", int'(ack), 0);

    // R5 monitor result
    chk("R5", "SDA drive changes while SCL high", viol, 0);

    done = 1'b1;
    summary;
    $finish;
  end

endmodule